// File: doc/BRIEF.md
# Pinned-Region True-LRU Tag and Replacement Controller

This block holds the tags, valid bits, dirty bits and recency state of a 4-way set-associative cache whose lines are loaded by software from slow backing storage. A lookup compares the tag against all four ways of the indexed set. On a hit it reports the way and makes that way the most recently used. On a miss it raises a precise fault carrying the missing address and changes no state. No hardware refill is started. The fault handler later issues a fill command. The controller then picks a victim, reports what the victim held, and installs the new tag.

The victim is the least recently used way whose line is not pinned. A line is pinned when it is valid and its base address lies below a programmable boundary. That low region holds the miss handler and the translation code, so those lines stay resident across every fill. Because the search may have to skip several ways, each way keeps a full 2-bit rank. Nothing is ever written back by the hardware. Software reads the victim's old tag and dirty bit from the fill response and cleans lines with an explicit command.

Top module: `pinned_lru_tagctl`

## Requirements
- R1: A lookup hit gives `resp_valid_o=1`, `resp_hit_o=1`, `resp_fault_o=0` and the matching way on `resp_way_o` in the cycle after the command. The hit makes that way the most recently used.
- R2: A lookup miss gives `resp_valid_o=1`, `resp_fault_o=1`, `resp_hit_o=0` and the lookup address on `fault_addr_o` one cycle later. It changes no tag, valid, dirty or recency state.
- R3: When a way is promoted, the ways that were more recent than it each move down one place and keep their relative order. The ways less recent than it keep their place.
- R4: A fill that does not hit picks the least recently used way that is not pinned. A way is pinned when it is valid and `{tag, set, zero offset} < pin_bound_i`. The response `fill_done_o=1` comes one cycle later with the way on `fill_way_o`.
- R5: When all four ways of the set are pinned, the fill sets `fill_err_o=1` and `fill_done_o=0`, and changes no state.
- R6: A completed fill reports the victim's old tag, old valid bit and old dirty bit. It installs the new line valid and clean as the most recently used way. No write-back takes place.
- R7: A lookup with `lookup_write_i=1` that hits sets that line's dirty bit. A clean command that hits clears the dirty bit and reports its previous value on `clean_was_dirty_o`, without changing recency. A clean that misses reports `clean_hit_o=0`.
- R8: Reset and `inval_all_i` clear every valid and dirty bit and reset the recency order so that way 0 is least recent and way 3 is most recent. As a result, fills into an empty set go to ways 0, 1, 2, 3 in that order.
- R9: Only one command is served per cycle. The priority is invalidate-all, then fill, then clean, then lookup. Commands that lose produce no response.
- R10: A fill whose address is already resident reuses that way. It reports the old contents of that way and makes the way the most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_bound_i | input | ADDR_W | Lines with base address below this value are pinned |
| inval_all_i | input | 1 | Invalidate all lines and reset recency |
| lookup_valid_i | input | 1 | Lookup command |
| lookup_write_i | input | 1 | Lookup is a store (sets dirty on hit) |
| lookup_addr_i | input | ADDR_W | Lookup address |
| fill_valid_i | input | 1 | Fill command from the miss handler |
| fill_addr_i | input | ADDR_W | Address of the line being installed |
| clean_valid_i | input | 1 | Explicit clean command |
| clean_addr_i | input | ADDR_W | Address of the line to clean |
| resp_valid_o | output | 1 | Lookup response valid |
| resp_hit_o | output | 1 | Lookup hit |
| resp_fault_o | output | 1 | Precise miss fault |
| resp_way_o | output | 2 | Way that hit |
| fault_addr_o | output | ADDR_W | Address that missed |
| fill_done_o | output | 1 | Fill completed |
| fill_err_o | output | 1 | Fill rejected: every way pinned |
| fill_way_o | output | 2 | Way that was written |
| fill_old_valid_o | output | 1 | Victim was valid |
| fill_old_tag_o | output | TAG_W | Victim's old tag |
| fill_old_dirty_o | output | 1 | Victim was dirty |
| clean_done_o | output | 1 | Clean command served |
| clean_hit_o | output | 1 | Clean address was resident |
| clean_was_dirty_o | output | 1 | Line was dirty before the clean |

## Verification
A corrupted rank stays hidden on hits, because a hit reports only the way index. It first shows at the ports on the next fill into that set, as a wrong `fill_way_o`. That can be many cycles after the fault, so the bench fills sets heavily and often and varies the pinned boundary to expose ordering errors deep in the order. A wrong dirty or valid bit shows one cycle after the next fill or clean that touches the line. A wrong tag shows one cycle after the next lookup, as a hit where a miss was expected, or the reverse.

// File: rtl/pinned_lru_pkg.sv
package pinned_lru_pkg;
  localparam int WAYS = 4;
  typedef logic [1:0] way_t;
  typedef logic [WAYS-1:0][1:0] rank_vec_t;

  // rank 0 = least recent, rank WAYS-1 = most recent
  function automatic rank_vec_t rank_init();
    rank_vec_t r;
    for (int w = 0; w < WAYS; w++) r[w] = 2'(w);
    return r;
  endfunction
endpackage

// File: rtl/lru_tag_match.sv
module lru_tag_match
  import pinned_lru_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output way_t                       way_o
);
  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_i[w] && tags_i[w] == tag_i) begin
        hit_o = 1'b1;
        way_o = 2'(w);
      end
    end
  end
endmodule

// File: rtl/lru_victim_walk.sv
module lru_victim_walk
  import pinned_lru_pkg::*;
(
  input  rank_vec_t       rank_i,
  input  logic [WAYS-1:0] pinned_i,
  output logic            found_o,
  output way_t            way_o
);
  // outer loop walks recency from least recent upward
  always_comb begin
    found_o = 1'b0;
    way_o   = '0;
    for (int k = 0; k < WAYS; k++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!found_o && rank_i[w] == 2'(k) && !pinned_i[w]) begin
          found_o = 1'b1;
          way_o   = 2'(w);
        end
      end
    end
  end
endmodule

// File: rtl/lru_promote.sv
module lru_promote
  import pinned_lru_pkg::*;
(
  input  rank_vec_t rank_i,
  input  way_t      way_i,
  output rank_vec_t rank_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_comb begin
      if (way_t'(w) == way_i)            rank_o[w] = 2'(WAYS - 1);
      else if (rank_i[w] > rank_i[way_i]) rank_o[w] = rank_i[w] - 2'd1;
      else                               rank_o[w] = rank_i[w];
    end
  end
endmodule

// File: rtl/pinned_lru_tagctl.sv
module pinned_lru_tagctl
  import pinned_lru_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 4,
  parameter int OFF_W  = 4,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pin_bound_i,
  input  logic              inval_all_i,
  input  logic              lookup_valid_i,
  input  logic              lookup_write_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              clean_valid_i,
  input  logic [ADDR_W-1:0] clean_addr_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_fault_o,
  output logic [1:0]        resp_way_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              fill_done_o,
  output logic              fill_err_o,
  output logic [1:0]        fill_way_o,
  output logic              fill_old_valid_o,
  output logic [TAG_W-1:0]  fill_old_tag_o,
  output logic              fill_old_dirty_o,
  output logic              clean_done_o,
  output logic              clean_hit_o,
  output logic              clean_was_dirty_o
);
  localparam int SETS = 1 << SET_W;

  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  rank_vec_t                  rank_q  [SETS];

  logic do_inval, do_fill, do_clean, do_look;
  assign do_inval = inval_all_i;
  assign do_fill  = !do_inval && fill_valid_i;
  assign do_clean = !do_inval && !fill_valid_i && clean_valid_i;
  assign do_look  = !do_inval && !fill_valid_i && !clean_valid_i && lookup_valid_i;

  logic [ADDR_W-1:0] cmd_addr;
  always_comb begin
    if (fill_valid_i)       cmd_addr = fill_addr_i;
    else if (clean_valid_i) cmd_addr = clean_addr_i;
    else                    cmd_addr = lookup_addr_i;
  end

  logic [SET_W-1:0] sel_set;
  logic [TAG_W-1:0] sel_tag;
  assign sel_set = cmd_addr[OFF_W +: SET_W];
  assign sel_tag = cmd_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            set_valid, set_dirty, pinned;
  rank_vec_t                  set_rank, new_rank;
  assign set_tags  = tag_q[sel_set];
  assign set_valid = valid_q[sel_set];
  assign set_dirty = dirty_q[sel_set];
  assign set_rank  = rank_q[sel_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_pin
    assign pinned[w] = set_valid[w] &&
                       ({set_tags[w], sel_set, {OFF_W{1'b0}}} < pin_bound_i);
  end

  logic hit, vic_found, fill_ok;
  way_t hit_way, vic_way, fill_way, upd_way;

  lru_tag_match #(.TAG_W(TAG_W)) u_match (
    .tags_i (set_tags),
    .valid_i(set_valid),
    .tag_i  (sel_tag),
    .hit_o  (hit),
    .way_o  (hit_way)
  );

  lru_victim_walk u_walk (
    .rank_i  (set_rank),
    .pinned_i(pinned),
    .found_o (vic_found),
    .way_o   (vic_way)
  );

  assign fill_way = hit ? hit_way : vic_way;
  assign fill_ok  = hit || vic_found;
  assign upd_way  = do_fill ? fill_way : hit_way;

  lru_promote u_prom (
    .rank_i(set_rank),
    .way_i (upd_way),
    .rank_o(new_rank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]   <= '0;
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        rank_q[s]  <= rank_init();
      end
    end else if (do_inval) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        rank_q[s]  <= rank_init();
      end
    end else if (do_fill && fill_ok) begin
      tag_q[sel_set][fill_way]   <= sel_tag;
      valid_q[sel_set][fill_way] <= 1'b1;
      dirty_q[sel_set][fill_way] <= 1'b0;
      rank_q[sel_set]            <= new_rank;
    end else if (do_clean && hit) begin
      dirty_q[sel_set][hit_way] <= 1'b0;
    end else if (do_look && hit) begin
      rank_q[sel_set] <= new_rank;
      if (lookup_write_i) dirty_q[sel_set][hit_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o      <= 1'b0;
      resp_hit_o        <= 1'b0;
      resp_fault_o      <= 1'b0;
      resp_way_o        <= '0;
      fault_addr_o      <= '0;
      fill_done_o       <= 1'b0;
      fill_err_o        <= 1'b0;
      fill_way_o        <= '0;
      fill_old_valid_o  <= 1'b0;
      fill_old_tag_o    <= '0;
      fill_old_dirty_o  <= 1'b0;
      clean_done_o      <= 1'b0;
      clean_hit_o       <= 1'b0;
      clean_was_dirty_o <= 1'b0;
    end else begin
      resp_valid_o      <= do_look;
      resp_hit_o        <= do_look && hit;
      resp_fault_o      <= do_look && !hit;
      resp_way_o        <= hit_way;
      fault_addr_o      <= lookup_addr_i;
      fill_done_o       <= do_fill && fill_ok;
      fill_err_o        <= do_fill && !fill_ok;
      fill_way_o        <= fill_way;
      fill_old_valid_o  <= set_valid[fill_way];
      fill_old_tag_o    <= set_tags[fill_way];
      fill_old_dirty_o  <= set_dirty[fill_way];
      clean_done_o      <= do_clean;
      clean_hit_o       <= do_clean && hit;
      clean_was_dirty_o <= do_clean && hit && set_dirty[hit_way];
    end
  end
endmodule

// File: rtl/pinned_lru_tagctl_chk.sv
module pinned_lru_tagctl_chk
  import pinned_lru_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 4,
  parameter int OFF_W  = 4,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W,
  localparam int SETS  = 1 << SET_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] pin_bound_i,
  input logic              inval_all_i,
  input logic              lookup_valid_i,
  input logic              fill_valid_i,
  input logic [ADDR_W-1:0] fill_addr_i,
  input logic              clean_valid_i,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic              resp_fault_o,
  input logic              fill_done_o,
  input logic              fill_err_o,
  input logic              fill_old_valid_o,
  input logic [TAG_W-1:0]  fill_old_tag_o,
  input logic              clean_done_o,
  input logic              clean_hit_o,
  input logic              clean_was_dirty_o,
  input rank_vec_t         rank_q [SETS]
);
  // R1 R2: a response is either a hit or a fault, never both
  assert_resp_kind_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_hit_o != resp_fault_o));

  // R4: an evicted line other than the refilled one was never pinned
  assert_victim_unpinned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_done_o && fill_old_valid_o &&
     fill_old_tag_o != $past(fill_addr_i[ADDR_W-1 -: TAG_W]))
    |-> ({fill_old_tag_o, $past(fill_addr_i[OFF_W +: SET_W]), {OFF_W{1'b0}}}
         >= $past(pin_bound_i)));

  // R5: rejection and completion are exclusive
  assert_fill_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_err_o |-> !fill_done_o);

  // R7: a clean that missed cannot report dirty data
  assert_clean_miss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean_done_o && !clean_hit_o) |-> !clean_was_dirty_o);

  // R8: a lone lookup right after invalidate-all misses
  assert_inval_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !fill_valid_i && !clean_valid_i && !inval_all_i &&
     $past(inval_all_i)) |=> resp_fault_o);

  // R3: ranks in every set stay a permutation
  for (genvar s = 0; s < SETS; s++) begin : g_perm
    logic [WAYS-1:0] seen;
    always_comb begin
      seen = '0;
      for (int w = 0; w < WAYS; w++) seen[rank_q[s][w]] = 1'b1;
    end
    assert_rank_perm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen == {WAYS{1'b1}});
  end
endmodule

bind pinned_lru_tagctl pinned_lru_tagctl_chk #(
  .ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)
) chk_i (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .pin_bound_i      (pin_bound_i),
  .inval_all_i      (inval_all_i),
  .lookup_valid_i   (lookup_valid_i),
  .fill_valid_i     (fill_valid_i),
  .fill_addr_i      (fill_addr_i),
  .clean_valid_i    (clean_valid_i),
  .resp_valid_o     (resp_valid_o),
  .resp_hit_o       (resp_hit_o),
  .resp_fault_o     (resp_fault_o),
  .fill_done_o      (fill_done_o),
  .fill_err_o       (fill_err_o),
  .fill_old_valid_o (fill_old_valid_o),
  .fill_old_tag_o   (fill_old_tag_o),
  .clean_done_o     (clean_done_o),
  .clean_hit_o      (clean_hit_o),
  .clean_was_dirty_o(clean_was_dirty_o),
  .rank_q           (rank_q)
);

// File: tb/pinned_lru_tagctl_tb_top.sv
`timescale 1ns/1ps
module pinned_lru_tagctl_tb_top;
  localparam int ADDR_W = 16;
  localparam int SET_W  = 4;
  localparam int OFF_W  = 4;
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int SETS   = 1 << SET_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic [ADDR_W-1:0] pin_bound_i = '0;
  logic inval_all_i = 0, lookup_valid_i = 0, lookup_write_i = 0;
  logic fill_valid_i = 0, clean_valid_i = 0;
  logic [ADDR_W-1:0] lookup_addr_i = '0, fill_addr_i = '0, clean_addr_i = '0;
  logic resp_valid_o, resp_hit_o, resp_fault_o;
  logic [1:0] resp_way_o, fill_way_o;
  logic [ADDR_W-1:0] fault_addr_o;
  logic fill_done_o, fill_err_o, fill_old_valid_o, fill_old_dirty_o;
  logic [TAG_W-1:0] fill_old_tag_o;
  logic clean_done_o, clean_hit_o, clean_was_dirty_o;

  pinned_lru_tagctl #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) dut_i (.*);

  int checks = 0;
  int errors = 0;

  // reference model: per-set recency queue, front = least recent
  int mtag [SETS][4];
  bit mval [SETS][4];
  bit mdty [SETS][4];
  int ord  [SETS][$];

  bit e_rv, e_hit, e_flt, e_fd, e_fe, e_fov, e_fod, e_cd, e_ch, e_cwd;
  int e_rway, e_faddr, e_fway, e_fotag;

  function automatic int mk(int tag, int set);
    return tag * (1 << (SET_W + OFF_W)) + set * (1 << OFF_W);
  endfunction

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      ord[s].delete();
      for (int w = 0; w < 4; w++) begin
        mval[s][w] = 0; mdty[s][w] = 0;
        ord[s].push_back(w);
      end
    end
  endtask

  task automatic promote(int s, int w);
    for (int i = 0; i < ord[s].size(); i++)
      if (ord[s][i] == w) begin ord[s].delete(i); break; end
    ord[s].push_back(w);
  endtask

  function automatic int find(int s, int t);
    for (int w = 0; w < 4; w++) if (mval[s][w] && mtag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic model_step();
    int a, s, t, w;
    e_rv = 0; e_hit = 0; e_flt = 0; e_fd = 0; e_fe = 0; e_cd = 0; e_ch = 0; e_cwd = 0;
    if (inval_all_i) begin
      model_reset();
    end else if (fill_valid_i) begin
      a = int'(fill_addr_i); s = (a >> OFF_W) % SETS; t = a >> (SET_W + OFF_W);
      w = find(s, t);
      if (w < 0)
        foreach (ord[s][i]) begin
          int c = ord[s][i];
          if (!(mval[s][c] && mk(mtag[s][c], s) < int'(pin_bound_i))) begin w = c; break; end
        end
      if (w < 0) e_fe = 1;
      else begin
        e_fd = 1; e_fway = w; e_fov = mval[s][w]; e_fotag = mtag[s][w]; e_fod = mdty[s][w];
        mtag[s][w] = t; mval[s][w] = 1; mdty[s][w] = 0;
        promote(s, w);
      end
    end else if (clean_valid_i) begin
      a = int'(clean_addr_i); s = (a >> OFF_W) % SETS; t = a >> (SET_W + OFF_W);
      w = find(s, t);
      e_cd = 1;
      if (w >= 0) begin e_ch = 1; e_cwd = mdty[s][w]; mdty[s][w] = 0; end
    end else if (lookup_valid_i) begin
      a = int'(lookup_addr_i); s = (a >> OFF_W) % SETS; t = a >> (SET_W + OFF_W);
      w = find(s, t);
      e_rv = 1;
      if (w >= 0) begin
        e_hit = 1; e_rway = w; promote(s, w);
        if (lookup_write_i) mdty[s][w] = 1;
      end else begin
        e_flt = 1; e_faddr = a;
      end
    end
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R9", "resp_valid", resp_valid_o, e_rv);
    if (e_rv) begin
      chk("R1", "resp_hit", resp_hit_o, e_hit);
      chk("R2", "resp_fault", resp_fault_o, e_flt);
      if (e_hit) chk("R1", "resp_way", resp_way_o, e_rway);
      if (e_flt) chk("R2", "fault_addr", fault_addr_o, e_faddr);
    end
    chk("R4", "fill_done", fill_done_o, e_fd);
    chk("R5", "fill_err", fill_err_o, e_fe);
    if (e_fd) begin
      chk("R3 R4", "fill_way", fill_way_o, e_fway);
      chk("R6", "old_valid", fill_old_valid_o, e_fov);
      if (e_fov) begin
        chk("R6", "old_tag", fill_old_tag_o, e_fotag);
        chk("R6 R7", "old_dirty", fill_old_dirty_o, e_fod);
      end
    end
    chk("R7", "clean_done", clean_done_o, e_cd);
    if (e_cd) begin
      chk("R7", "clean_hit", clean_hit_o, e_ch);
      chk("R7", "clean_was_dirty", clean_was_dirty_o, e_cwd);
    end
  endtask

  task automatic idle();
    inval_all_i = 0; lookup_valid_i = 0; lookup_write_i = 0;
    fill_valid_i = 0; clean_valid_i = 0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all();
    idle();
  endtask

  task automatic do_look(int a, bit wr);
    lookup_valid_i = 1; lookup_write_i = wr; lookup_addr_i = ADDR_W'(a); tick();
  endtask
  task automatic do_fill(int a);
    fill_valid_i = 1; fill_addr_i = ADDR_W'(a); tick();
  endtask
  task automatic do_clean(int a);
    clean_valid_i = 1; clean_addr_i = ADDR_W'(a); tick();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    // R8: outputs quiet in reset
    chk("R8", "reset resp_valid", resp_valid_o, 0);
    chk("R8", "reset fill_done", fill_done_o, 0);
    chk("R8", "reset clean_done", clean_done_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    do_look(mk(1, 0) + 3, 0);                     // R2 miss
    chk("R2", "miss fault", resp_fault_o, 1);
    for (int t = 1; t <= 4; t++) begin            // R8 fill order 0..3
      do_fill(mk(t, 0));
      chk("R8", "empty-set fill way", fill_way_o, t - 1);
    end
    do_look(mk(1, 0), 0);
    chk("R1", "hit way", resp_way_o, 0);
    do_look(mk(2, 0), 1);                         // R7 store hit sets dirty
    do_fill(mk(5, 0));                            // R3: order w2,w3,w0,w1
    chk("R3", "victim after promotions", fill_way_o, 2);
    chk("R6", "victim old tag", fill_old_tag_o, 3);
    pin_bound_i = ADDR_W'(mk(5, 0));              // tags 1,2,4 pinned
    do_fill(mk(6, 0));
    chk("R4", "skip three pinned", fill_way_o, 2);
    pin_bound_i = ADDR_W'(mk(7, 0));              // all pinned
    do_fill(mk(9, 0));
    chk("R5", "all pinned rejected", fill_err_o, 1);
    do_look(mk(9, 0), 0);
    chk("R5", "rejected line absent", resp_fault_o, 1);
    pin_bound_i = '0;
    do_clean(mk(2, 0));
    chk("R7", "clean reports dirty", clean_was_dirty_o, 1);
    do_clean(mk(2, 0));
    chk("R7", "second clean clean", clean_was_dirty_o, 0);
    do_look(mk(2, 0), 1);
    do_fill(mk(2, 0));                            // R10 resident refill
    chk("R10", "refill reuses way", fill_way_o, 1);
    chk("R10", "refill old dirty", fill_old_dirty_o, 1);
    fill_valid_i = 1; fill_addr_i = ADDR_W'(mk(3, 1));
    lookup_valid_i = 1; lookup_addr_i = ADDR_W'(mk(4, 1));
    tick();
    chk("R9", "fill beats lookup", resp_valid_o, 0);
    inval_all_i = 1; fill_valid_i = 1; fill_addr_i = ADDR_W'(mk(5, 1));
    tick();
    chk("R9", "inval beats fill", fill_done_o, 0);
    do_look(mk(1, 0), 0);
    chk("R8", "miss after inval", resp_fault_o, 1);
    do_fill(mk(7, 0));
    chk("R8", "inval resets order", fill_way_o, 0);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      int a = mk($urandom % 8, $urandom % 2) + ($urandom % 16);
      if (n % 150 == 0) pin_bound_i = ADDR_W'(mk($urandom % 9, 0));
      if (r < 2) inval_all_i = 1;
      if (r >= 2 && r < 35) begin fill_valid_i = 1; fill_addr_i = ADDR_W'(a); end
      if (r >= 30 && r < 45) begin clean_valid_i = 1; clean_addr_i = ADDR_W'(a); end
      if (r >= 40) begin
        lookup_valid_i = 1; lookup_write_i = $urandom % 2;
        lookup_addr_i = ADDR_W'(mk($urandom % 8, $urandom % 2));
      end
      tick();
    end
    summary();
  end
endmodule